// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block models the command side of a byte-wide parallel NOR flash. A host drives a chip-select, a read strobe, a write strobe, an 18-bit address and an 8-bit data bus, all active low on the strobes, and the block samples them on its own clock. Qualified write cycles are assembled into unlock sequences. A complete sequence starts a byte program, a full-array erase or a single-sector erase, enters the identification mode, or returns the block to plain reading. A wrong step anywhere in a sequence drops it back to reading. The identification mode returns a maker code, a device code and per-sector lock state in place of array data.

Storage is an internal RAM. Each of the seven sectors gets a window of `2**MEM_AW` bytes, and the addresses inside a sector fold onto that window by their low bits. Sector locks come from an input vector. One input lifts all locks while it is held. Program can only clear bits. Erase returns bytes to FFh.

Top module: `flash_cmd_if`

## Requirements
- R1: A bus write counts only while `ce_n`=0, `we_n`=0 and `oe_n`=1 at the same time. A write attempted with `oe_n` low has no effect on the command state or the array.
- R2: The address of a write is the one present when the qualifying window opens. The data of a write is the last value present before the window closes.
- R3: After reset the block is in read mode with `busy`=0 and `dout_en`=0. Unwritten bytes read FFh. `dout_en` is high only for a read window (`ce_n`=0, `oe_n`=0, `we_n`=1).
- R4: Byte program is the writes AAh@555h, 55h@2AAh, A0h@555h and then the target address with its data. Only the low 11 address bits are compared for the unlock addresses.
- R5: Program stores the AND of the old byte and the new byte, so a 0 never returns to 1 through a program.
- R6: Sector erase is the writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h at any address inside the sector. It sets every byte of that sector to FFh and leaves the other sectors unchanged.
- R7: Full erase is the same as R6 except that the final write is 10h@555h. It sets every byte of every unlocked sector to FFh.
- R8: A write with the wrong address or data mid-sequence, or a write of F0h at any step, returns the block to read mode. A later data write then programs nothing.
- R9: `busy` is high while a program or erase runs. Every write during that time, including F0h, is ignored, and the running operation completes.
- R10: The identification mode is entered with AAh@555h, 55h@2AAh, 90h@555h. Reads then return values by the low address byte: 00h gives 01h; 01h gives B0h (top-boot) or 34h (bottom-boot); 02h gives 01h if the addressed sector is locked and 00h if not. Only an F0h write leaves the mode.
- R11: Sectors are decoded from address bits 17..13. The top-boot layout in address order is 64K, 64K, 64K, 32K, 8K, 8K, 16K. The bottom-boot layout is 16K, 8K, 8K, 32K, 64K, 64K, 64K. Sectors are numbered 0 to 6 from low addresses upward, and that number indexes `sect_lock`.
- R12: A program or sector erase aimed at a locked sector is dropped, and `busy` stays low. A full erase skips locked sectors. While `unprot`=1, no sector is treated as locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| sect_lock | input | 7 | Per-sector lock, bit n for sector n |
| unprot | input | 1 | Lifts all sector locks while high |
| dout | output | 8 | Read data, 00h outside a read |
| dout_en | output | 1 | High when dout carries read data |
| busy | output | 1 | Program or erase in progress |

## Verification
Read data reaches `dout` three rising edges after the bus pins settle: one edge for the pin sample, one for the RAM or ID register, and one for the output register. The bench therefore holds each read for three clock periods and compares at the following falling edge. A write becomes a command two edges after its window closes. The engine starts one edge after that, so the bench allows six cycles before it samples `busy` and then waits for `busy` to drop before it reads back. Erases take one cycle per byte: a sector window of 256 cycles, or 2048 cycles for the full array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW     = 8;
  localparam int NSECT  = 7;
  localparam int SECT_W = 3;
  localparam int UA_W   = 11;

  localparam logic [UA_W-1:0] UNLK_ADDR1 = 11'h555;
  localparam logic [UA_W-1:0] UNLK_ADDR2 = 11'h2AA;
  localparam logic [DW-1:0]   UNLK_DATA1 = 8'hAA;
  localparam logic [DW-1:0]   UNLK_DATA2 = 8'h55;
  localparam logic [DW-1:0]   CMD_PROG   = 8'hA0;
  localparam logic [DW-1:0]   CMD_ERSET  = 8'h80;
  localparam logic [DW-1:0]   CMD_CHIP   = 8'h10;
  localparam logic [DW-1:0]   CMD_SECT   = 8'h30;
  localparam logic [DW-1:0]   CMD_IDENT  = 8'h90;
  localparam logic [DW-1:0]   CMD_RESET  = 8'hF0;
  localparam logic [DW-1:0]   MAKER_CODE = 8'h01;
  localparam logic [DW-1:0]   DEV_TOP    = 8'hB0;
  localparam logic [DW-1:0]   DEV_BOT    = 8'h34;

  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_CHIP, OP_SECT} op_kind_t;

  typedef enum logic [2:0] {
    C_READ, C_U1, C_U2, C_PSET, C_ESET, C_E1, C_E2, C_IDENT
  } cmd_state_t;

  // Maps the five top address bits to a sector number 0..6.
  function automatic logic [SECT_W-1:0] sector_of(input logic [4:0] h, input logic top);
    if (top) begin
      if (h[4:3] != 2'b11)  return {1'b0, h[4:3]};
      else if (!h[2])       return 3'd3;
      else if (h[1])        return 3'd6;
      else                  return h[0] ? 3'd5 : 3'd4;
    end else begin
      if (h[4:3] != 2'b00)  return 3'd3 + {1'b0, h[4:3]};
      else if (h[2])        return 3'd3;
      else if (!h[1])       return 3'd0;
      else                  return h[0] ? 3'd2 : 3'd1;
    end
  endfunction
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              rd_active,
  output logic [ADDR_W-1:0] rd_addr
);
  logic              s_ce, s_oe, s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [DW-1:0]     s_din;
  logic              win_now, win_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [DW-1:0]     cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce   <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce   <= ce_n;
      s_oe   <= oe_n;
      s_we   <= we_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  assign win_now   = !s_ce && !s_we && s_oe;
  assign rd_active = !s_ce && !s_oe && s_we;
  assign rd_addr   = s_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      win_q     <= win_now;
      wr_strobe <= 1'b0;
      if (win_now && !win_q) cap_addr <= s_addr;
      if (win_now)           cap_data <= s_din;
      if (win_q && !win_now) begin
        wr_strobe <= 1'b1;
        wr_addr   <= cap_addr;
        wr_data   <= cap_data;
      end
    end
  end

  // R1: a write strobe only follows a window that was open two samples back
  a_r1_strobe_after_window: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_strobe) |-> $past(win_q));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int MEM_AW   = 8,
  parameter bit TOP_BOOT = 1'b1,
  localparam int IW      = SECT_W + MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              busy,
  input  logic [NSECT-1:0]  lock,
  input  logic              unprot,
  output logic              ident_mode,
  output logic              op_start,
  output op_kind_t          op_kind,
  output logic [IW-1:0]     op_idx,
  output logic [DW-1:0]     op_data,
  output logic [7:0]        op_allow
);
  cmd_state_t        state;
  logic [SECT_W-1:0] sect;
  logic [7:0]        allow_vec;
  logic              is_u1, is_u2, at_u1;
  logic              unused_bits;

  assign sect        = sector_of(wr_addr[ADDR_W-1 -: 5], TOP_BOOT);
  assign allow_vec   = {1'b1, ~lock | {NSECT{unprot}}};
  assign at_u1       = wr_addr[UA_W-1:0] == UNLK_ADDR1;
  assign is_u1       = at_u1 && wr_data == UNLK_DATA1;
  assign is_u2       = wr_addr[UA_W-1:0] == UNLK_ADDR2 && wr_data == UNLK_DATA2;
  assign ident_mode  = state == C_IDENT;
  assign unused_bits = ^wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= C_READ;
      op_start <= 1'b0;
      op_kind  <= OP_NONE;
      op_idx   <= '0;
      op_data  <= '0;
      op_allow <= '0;
    end else begin
      op_start <= 1'b0;
      if (wr_strobe && !busy) begin
        case (state)
          C_READ:  state <= is_u1 ? C_U1 : C_READ;
          C_U1:    state <= is_u2 ? C_U2 : C_READ;
          C_U2: begin
            if (at_u1 && wr_data == CMD_PROG)       state <= C_PSET;
            else if (at_u1 && wr_data == CMD_ERSET) state <= C_ESET;
            else if (at_u1 && wr_data == CMD_IDENT) state <= C_IDENT;
            else                                    state <= C_READ;
          end
          C_PSET: begin
            state <= C_READ;
            if (allow_vec[sect]) begin
              op_start <= 1'b1;
              op_kind  <= OP_PROG;
              op_idx   <= {sect, wr_addr[MEM_AW-1:0]};
              op_data  <= wr_data;
              op_allow <= allow_vec;
            end
          end
          C_ESET:  state <= is_u1 ? C_E1 : C_READ;
          C_E1:    state <= is_u2 ? C_E2 : C_READ;
          C_E2: begin
            state <= C_READ;
            if (at_u1 && wr_data == CMD_CHIP) begin
              op_start <= 1'b1;
              op_kind  <= OP_CHIP;
              op_idx   <= '0;
              op_allow <= allow_vec;
            end else if (wr_data == CMD_SECT && allow_vec[sect]) begin
              op_start <= 1'b1;
              op_kind  <= OP_SECT;
              op_idx   <= {sect, {MEM_AW{1'b0}}};
              op_allow <= allow_vec;
            end
          end
          C_IDENT: if (wr_data == CMD_RESET) state <= C_READ;
          default: state <= C_READ;
        endcase
      end
    end
  end

  // R9: no new operation may start while one is running
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !op_start);
  // R9: sequence state is frozen while an operation runs
  a_r9_hold_state: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(state));
  // R8: an F0h write outside a running operation always returns to read mode
  a_r8_reset_aborts: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe && !busy && wr_data == CMD_RESET) |=> state == C_READ);
  // R10: identification mode persists until an F0h write
  a_r10_ident_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == C_IDENT && !(wr_strobe && wr_data == CMD_RESET)) |=> state == C_IDENT);
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW = 8,
  localparam int IW    = SECT_W + MEM_AW,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  op_kind_t      op_kind,
  input  logic [IW-1:0] op_idx,
  input  logic [DW-1:0] op_data,
  input  logic [7:0]    op_allow,
  input  logic [IW-1:0] bus_idx,
  output logic [DW-1:0] ram_q,
  output logic          busy
);
  typedef enum logic [1:0] {E_IDLE, E_PRD, E_PWR, E_ERASE} eng_state_t;

  logic [DW-1:0] mem [DEPTH];
  eng_state_t    st;
  op_kind_t      kind_q;
  logic [IW-1:0] idx_q, cnt, cur_idx, rd_idx;
  logic [DW-1:0] data_q, wr_val;
  logic [7:0]    alw_q;
  logic          mem_we, last;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  assign busy    = st != E_IDLE;
  assign cur_idx = (st != E_ERASE)   ? idx_q :
                   (kind_q == OP_CHIP) ? cnt :
                   {idx_q[IW-1 -: SECT_W], cnt[MEM_AW-1:0]};
  assign rd_idx  = busy ? cur_idx : bus_idx;
  assign last    = (kind_q == OP_CHIP) ? &cnt : &cnt[MEM_AW-1:0];

  always_comb begin
    mem_we = 1'b0;
    wr_val = '1;
    if (st == E_PWR) begin
      mem_we = 1'b1;
      wr_val = ram_q & data_q;
    end else if (st == E_ERASE) begin
      mem_we = alw_q[cur_idx[IW-1 -: SECT_W]];
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[cur_idx] <= wr_val;
    ram_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      kind_q <= OP_NONE;
      idx_q  <= '0;
      data_q <= '0;
      alw_q  <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        E_IDLE: if (op_start) begin
          kind_q <= op_kind;
          idx_q  <= op_idx;
          data_q <= op_data;
          alw_q  <= op_allow;
          cnt    <= '0;
          st     <= (op_kind == OP_PROG) ? E_PRD : E_ERASE;
        end
        E_PRD:   st <= E_PWR;
        E_PWR:   st <= E_IDLE;
        E_ERASE: begin
          cnt <= cnt + 1'b1;
          if (last) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // R4: the decoder only hands over work when the engine is idle
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    op_start |-> st == E_IDLE);
  // R5: a program write never raises a bit that read back as zero
  a_r5_and_only: assert property (@(posedge clk) disable iff (rst)
    (st == E_PWR) |=> (mem[$past(cur_idx)] & ~$past(ram_q)) == '0);
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int MEM_AW   = 8,
  parameter bit TOP_BOOT = 1'b1,
  localparam int IW      = SECT_W + MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  input  logic [NSECT-1:0]  sect_lock,
  input  logic              unprot,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  output logic              busy
);
  logic              wr_strobe, rd_active, ident_mode, op_start;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DW-1:0]     wr_data, op_data, ram_q, id_val, id_q;
  op_kind_t          op_kind;
  logic [IW-1:0]     op_idx, bus_idx;
  logic [7:0]        op_allow, lock8;
  logic [SECT_W-1:0] rd_sect;
  logic              en_q, sel_q;
  logic              unused_rd;

  flash_bus_sampler #(.ADDR_W(ADDR_W)) smp_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_active(rd_active), .rd_addr(rd_addr));

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .TOP_BOOT(TOP_BOOT)) dec_i (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .lock(sect_lock), .unprot(unprot),
    .ident_mode(ident_mode), .op_start(op_start), .op_kind(op_kind),
    .op_idx(op_idx), .op_data(op_data), .op_allow(op_allow));

  flash_op_engine #(.MEM_AW(MEM_AW)) eng_i (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_idx(op_idx), .op_data(op_data), .op_allow(op_allow),
    .bus_idx(bus_idx), .ram_q(ram_q), .busy(busy));

  assign rd_sect   = sector_of(rd_addr[ADDR_W-1 -: 5], TOP_BOOT);
  assign bus_idx   = {rd_sect, rd_addr[MEM_AW-1:0]};
  assign lock8     = {1'b0, sect_lock};
  assign unused_rd = ^rd_addr;

  always_comb begin
    case (rd_addr[7:0])
      8'h00:   id_val = MAKER_CODE;
      8'h01:   id_val = TOP_BOOT ? DEV_TOP : DEV_BOT;
      8'h02:   id_val = {7'b0, lock8[rd_sect]};
      default: id_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      sel_q   <= 1'b0;
      id_q    <= '0;
      dout_en <= 1'b0;
      dout    <= '0;
    end else begin
      en_q    <= rd_active;
      sel_q   <= ident_mode;
      id_q    <= id_val;
      dout_en <= en_q;
      dout    <= en_q ? (sel_q ? id_q : ram_q) : '0;
    end
  end

  // R3: output data is only presented for a read window three samples back
  a_r3_read_window: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> $past(!ce_n && !oe_n && we_n, 3));
endmodule

// File: tb/flash_cmd_if_tb.sv
module flash_cmd_if_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [6:0]  sect_lock = 7'b0000100;
  logic        unprot = 1'b0;
  logic [7:0]  dout;
  logic        dout_en, busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t exp_q[$];
  event smp_ev;

  always #5 clk = ~clk;

  flash_cmd_if dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .sect_lock(sect_lock), .unprot(unprot),
    .dout(dout), .dout_en(dout_en), .busy(busy));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read result when the driver marks a sample point
  initial begin
    exp_t e;
    forever begin
      @(smp_ev);
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: sample with empty queue, actual %h expected none", dout);
      end else begin
        e = exp_q.pop_front();
        if (dout !== e.exp || dout_en !== 1'b1)
          begin
            n_fail++;
            $display("FAIL %s: actual %h en=%b expected %h en=1", e.tag, dout, dout_en, e.exp);
          end
      end
    end
  end

  task automatic bw(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 0; we_n = 0; oe_n = 1;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic br(input logic [17:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    repeat (3) @(negedge clk);
    -> smp_ev;
    #1;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    repeat (6) @(negedge clk);
    while (busy && g < 6000) begin @(negedge clk); g++; end
  endtask

  task automatic unlock2();
    bw(18'h00555, 8'hAA);
    bw(18'h002AA, 8'h55);
  endtask

  task automatic prog(input logic [17:0] a, input logic [7:0] d);
    unlock2(); bw(18'h00555, 8'hA0); bw(a, d); wait_idle();
  endtask

  task automatic erase_pre();
    unlock2(); bw(18'h00555, 8'h80); unlock2();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R3 reset state
    check({7'b0, busy}, 8'h00, "R3 busy after reset");
    check({7'b0, dout_en}, 8'h00, "R3 dout_en after reset");
    br(18'h00000, 8'hFF, "R3 blank read");

    // R4 program
    prog(18'h00010, 8'h5A);
    br(18'h00010, 8'h5A, "R4 program");
    // R5 AND behaviour
    prog(18'h00010, 8'hF0);
    br(18'h00010, 8'h50, "R5 and of old and new");

    // R1 inhibited first unlock (oe_n low)
    @(negedge clk);
    addr = 18'h00555; din = 8'hAA; ce_n = 0; we_n = 0; oe_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    bw(18'h002AA, 8'h55); bw(18'h00555, 8'hA0); bw(18'h00020, 8'h12); wait_idle();
    br(18'h00020, 8'hFF, "R1 write inhibited by oe_n");

    // R2 address at window open, data at window close
    unlock2(); bw(18'h00555, 8'hA0);
    @(negedge clk);
    addr = 18'h00030; din = 8'h11; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    addr = 18'h00031; din = 8'h3C;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1;
    wait_idle();
    br(18'h00030, 8'h3C, "R2 captured address and data");
    br(18'h00031, 8'hFF, "R2 later address not used");

    // R8 wrong value and F0 abort
    unlock2(); bw(18'h00555, 8'h77); bw(18'h00555, 8'hA0); bw(18'h00040, 8'h00); wait_idle();
    br(18'h00040, 8'hFF, "R8 wrong command aborts");
    unlock2(); bw(18'h00555, 8'hF0); bw(18'h00555, 8'hA0); bw(18'h00041, 8'h00); wait_idle();
    br(18'h00041, 8'hFF, "R8 reset aborts");

    // R10 identification mode
    unlock2(); bw(18'h00555, 8'h90);
    br(18'h00000, 8'h01, "R10 maker code");
    br(18'h00001, 8'hB0, "R10 device code");
    br(18'h20002, 8'h01, "R10 locked sector");
    br(18'h00002, 8'h00, "R10 unlocked sector");
    bw(18'h00555, 8'hAA);
    br(18'h00000, 8'h01, "R10 mode persists");
    bw(18'h00000, 8'hF0);
    br(18'h00010, 8'h50, "R10 exit to array");

    // R12 locked program dropped, then allowed with unprot
    prog(18'h20005, 8'h00);
    br(18'h20005, 8'hFF, "R12 locked program dropped");
    unprot = 1;
    prog(18'h20005, 8'h00);
    unprot = 0;
    br(18'h20005, 8'h00, "R12 unprot allows program");

    // R6 / R11 sector erase with top-boot map, R9 busy and ignored reset
    prog(18'h39F00, 8'h00);
    prog(18'h3A000, 8'h00);
    prog(18'h37000, 8'h00);
    erase_pre(); bw(18'h38000, 8'h30);
    repeat (6) @(negedge clk);
    check({7'b0, busy}, 8'h01, "R9 busy during erase");
    bw(18'h00000, 8'hF0);
    check({7'b0, busy}, 8'h01, "R9 reset ignored while busy");
    wait_idle();
    br(18'h39F00, 8'hFF, "R6 sector 4 erased");
    br(18'h3A000, 8'h00, "R11 sector 5 untouched");
    br(18'h37000, 8'h00, "R11 sector 3 untouched");

    // R11 16K top sector
    prog(18'h3FFFF, 8'h00);
    prog(18'h3BFFF, 8'h00);
    erase_pre(); bw(18'h3C123, 8'h30); wait_idle();
    br(18'h3FFFF, 8'hFF, "R11 sector 6 erased");
    br(18'h3BFFF, 8'h00, "R11 sector 5 kept");

    // R12 sector erase of locked sector dropped
    erase_pre(); bw(18'h20000, 8'h30);
    repeat (6) @(negedge clk);
    check({7'b0, busy}, 8'h00, "R12 locked erase no busy");
    br(18'h20005, 8'h00, "R12 locked erase dropped");

    // R7 full erase skips locked sector
    erase_pre(); bw(18'h00555, 8'h10); wait_idle();
    br(18'h00010, 8'hFF, "R7 sector 0 erased");
    br(18'h3A000, 8'hFF, "R7 sector 5 erased");
    br(18'h20005, 8'h00, "R12 full erase keeps locked");
    check({7'b0, busy}, 8'h00, "R9 idle after erase");

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule